// File: doc/BRIEF.md
# Capture Input Front End for a Timer

This block sits between three asynchronous input pins and a free-running timer. Each pin is brought into the clock domain, and its rising and falling edges are found. Per channel, a selected edge copies the current timer value into that channel's capture register. If the channel's interrupt enable is set, the same event also raises a sticky capture flag. Software clears a flag by writing one to its bit.

The same synchronised pins can play a second role. A count control word can make the timer advance on edges of one chosen pin instead of on every clock. It can also clear the timer and its prescaler on one chosen edge of one chosen pin. The timer counter itself lives outside this block. The block receives the timer value and returns a count-advance strobe and a clear strobe. The two roles use separate edge encodings.

Top module: `cap_front`

## Requirements
- R1: After synchronous reset, every capture value is zero, every capture flag is zero, and no edge is reported on any channel until new pin levels have passed through the synchroniser.
- R2: A pin level driven before clock edge k produces an edge event during the cycle between edges k+1 and k+2. The capture register loads at edge k+2 with the timer value present in that cycle.
- R3: For channel n, `cap_cfg` bit 3n enables capture on rising edges (a 0 sample followed by a 1 sample) and bit 3n+1 enables capture on falling edges. With both bits set, either edge captures. Without a selected edge, the capture value holds, and no port other than the pin can change it.
- R4: A capture load on channel n sets flag n when `cap_cfg` bit 3n+2 is set. The flag stays set until cleared. If a set and a clear fall in the same cycle, the flag ends up set.
- R5: `flag_clr` is write-one-to-clear. A one in bit n clears flag n at the next edge, and a zero bit leaves its flag unchanged.
- R6: `cnt_cfg[1:0]` picks the count source: 0 gives `count_tick` high on every cycle, 1 gives it on rising edges, 2 on falling edges, and 3 on both edges of the pin chosen by `cnt_cfg[3:2]`.
- R7: In the edge-counting modes (1 to 3), a `cnt_cfg[3:2]` value of 3 names no pin, and `count_tick` stays low.
- R8: With `cnt_cfg[4]` set, `cnt_cfg[7:5]` code c in 0..5 picks pin c/2, with a rising edge for even c and a falling edge for odd c. That edge drives `timer_clear` high for one cycle, in the same cycle as the edge event of R2.
- R9: `timer_clear` stays low when `cnt_cfg[4]` is clear, or when `cnt_cfg[7:5]` holds the reserved codes 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | NCH | Asynchronous capture/count pins |
| timer_val | input | TW | Current value of the external timer counter |
| cap_cfg | input | 3*NCH | Per-channel rise enable, fall enable, interrupt enable |
| cnt_cfg | input | 8 | Count mode, count pin, clear enable, clear edge code |
| flag_clr | input | NCH | Write-one-to-clear strobes for the capture flags |
| cap_value | output | NCH*TW | Capture registers, channel n at bits n*TW upward |
| cap_flags | output | NCH | Sticky capture flags |
| count_tick | output | 1 | Timer advance strobe |
| timer_clear | output | 1 | Timer and prescaler clear strobe |

## Verification
The bench checks the exact cycle in which a capture lands. A design with one synchroniser stage too few or too many would latch a neighbouring timer value. It drives a flag set and a flag clear in the same cycle, where a design that gave priority to the clear would lose an event. It also writes zero clear bits, where a plain write rather than a clear-on-one would wipe the other flags. Pin select value 3 and the reserved clear codes 6 and 7 are exercised while the pins toggle, so a decoder that wrapped or aliased them would produce spurious ticks or clears. Long stretches of pseudo-random pin activity across every count mode and clear code are compared against the behavioural model on every clock.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        CNT_TIMER = 2'd0,
        CNT_RISE  = 2'd1,
        CNT_FALL  = 2'd2,
        CNT_BOTH  = 2'd3
    } cnt_mode_e;

    // Count control word, most significant field first.
    typedef struct packed {
        logic [2:0] clr_code;   // [7:5] clear edge: channel = code/2, odd = falling
        logic       clr_en;     // [4]
        logic [1:0] in_sel;     // [3:2] pin used for counting
        cnt_mode_e  mode;       // [1:0]
    } cnt_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic irq_en;
        logic fall_en;
        logic rise_en;
    } cap_ctrl_t;

    function automatic logic edge_pick(edge_t ev, logic want_rise, logic want_fall);
        return (ev.rise & want_rise) | (ev.fall & want_fall);
    endfunction

endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync
    import cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output edge_t ev
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign ev.rise = sync_q & ~last_q;
    assign ev.fall = ~sync_q & last_q;

    // R2
    rise_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ev.rise |-> $past(pin, 2));
    // R2
    fall_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ev.fall |-> !$past(pin, 2));

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  edge_t         ev,
    input  cap_ctrl_t     ctl,
    input  logic [TW-1:0] tval,
    input  logic          clr,
    output logic [TW-1:0] cap,
    output logic          flag
);
    logic load;
    logic raise;

    assign load  = edge_pick(ev, ctl.rise_en, ctl.fall_en);
    assign raise = load & ctl.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap  <= '0;
            flag <= 1'b0;
        end else begin
            if (load) cap <= tval;
            flag <= (flag & ~clr) | raise;
        end
    end

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cap == $past(tval));
    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cap));
    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rise || ev.fall) && ctl.irq_en && load |=> flag);
    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr && !load |=> !flag);
    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        flag && !clr |=> flag);

endmodule

// File: rtl/cap_count_sel.sv
module cap_count_sel
    import cap_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  cnt_ctrl_t           ctl,
    input  edge_t [NCH-1:0]     evs,
    output logic                tick,
    output logic                tclr
);
    edge_t cnt_ev;
    edge_t clr_ev;
    logic  clr_hit;

    always_comb begin
        cnt_ev = '0;
        clr_ev = '0;
        clr_hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(ctl.in_sel) == i) cnt_ev = evs[i];
            if (int'(ctl.clr_code[2:1]) == i) begin
                clr_ev  = evs[i];
                clr_hit = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (ctl.mode)
            CNT_TIMER: tick = 1'b1;
            CNT_RISE:  tick = cnt_ev.rise;
            CNT_FALL:  tick = cnt_ev.fall;
            CNT_BOTH:  tick = cnt_ev.rise | cnt_ev.fall;
            default:   tick = 1'b0;
        endcase
    end

    assign tclr = ctl.clr_en & clr_hit &
                  edge_pick(clr_ev, ~ctl.clr_code[0], ctl.clr_code[0]);

    // R6
    timer_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.mode == CNT_TIMER |-> tick);
    // R7
    bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode != CNT_TIMER && int'(ctl.in_sel) >= NCH) |-> !tick);
    // R9
    clr_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr_en || int'(ctl.clr_code[2:1]) >= NCH) |-> !tclr);
    // R8
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tclr |=> !tclr);

endmodule

// File: rtl/cap_front.sv
module cap_front
    import cap_pkg::*;
#(
    parameter int NCH = 3,
    parameter int TW  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH-1:0]     cap_pin,
    input  logic [TW-1:0]      timer_val,
    input  logic [3*NCH-1:0]   cap_cfg,
    input  logic [7:0]         cnt_cfg,
    input  logic [NCH-1:0]     flag_clr,
    output logic [NCH*TW-1:0]  cap_value,
    output logic [NCH-1:0]     cap_flags,
    output logic               count_tick,
    output logic               timer_clear
);
    localparam int CFG_W = $bits(cap_ctrl_t);

    edge_t [NCH-1:0] evs;
    cnt_ctrl_t       cnt_ctl;

    assign cnt_ctl = cnt_ctrl_t'(cnt_cfg);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        cap_ctrl_t ch_ctl;
        assign ch_ctl = cap_ctrl_t'(cap_cfg[c*CFG_W +: CFG_W]);

        cap_edge_sync u_sync (
            .clk (clk),
            .rst (rst),
            .pin (cap_pin[c]),
            .ev  (evs[c])
        );

        cap_channel #(.TW(TW)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .ev   (evs[c]),
            .ctl  (ch_ctl),
            .tval (timer_val),
            .clr  (flag_clr[c]),
            .cap  (cap_value[c*TW +: TW]),
            .flag (cap_flags[c])
        );
    end

    cap_count_sel #(.NCH(NCH)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .ctl  (cnt_ctl),
        .evs  (evs),
        .tick (count_tick),
        .tclr (timer_clear)
    );

endmodule

// File: tb/cap_front_tb.sv
module cap_front_tb;
    localparam int CLK_P = 10;
    localparam int NCH   = 3;
    localparam int TW    = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NCH-1:0]     cap_pin = '0;
    logic [TW-1:0]      timer_val = '0;
    logic [3*NCH-1:0]   cap_cfg = '0;
    logic [7:0]         cnt_cfg = '0;
    logic [NCH-1:0]     flag_clr = '0;
    logic [NCH*TW-1:0]  cap_value;
    logic [NCH-1:0]     cap_flags;
    logic               count_tick;
    logic               timer_clear;

    int n_cmp = 0;
    int n_bad = 0;
    bit armed = 0;
    bit done  = 0;

    // behavioural model
    bit          hq [NCH][$];
    logic [TW-1:0] m_cap [NCH];
    logic [NCH-1:0] m_flag;

    always #(CLK_P/2) clk = ~clk;

    cap_front #(.NCH(NCH), .TW(TW)) u_dut (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .timer_val(timer_val),
        .cap_cfg(cap_cfg), .cnt_cfg(cnt_cfg), .flag_clr(flag_clr),
        .cap_value(cap_value), .cap_flags(cap_flags),
        .count_tick(count_tick), .timer_clear(timer_clear)
    );

    function automatic bit m_rise(int c);
        return hq[c][1] && !hq[c][2];
    endfunction
    function automatic bit m_fall(int c);
        return !hq[c][1] && hq[c][2];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                hq[c].delete();
                repeat (3) hq[c].push_back(1'b0);
                m_cap[c] = '0;
            end
            m_flag = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit ld;
                ld = (m_rise(c) && cap_cfg[3*c]) || (m_fall(c) && cap_cfg[3*c+1]);
                if (ld) m_cap[c] = timer_val;
                m_flag[c] = (m_flag[c] && !flag_clr[c]) || (ld && cap_cfg[3*c+2]);
                hq[c].push_front(cap_pin[c]);
                void'(hq[c].pop_back());
            end
        end
    end

    function automatic bit m_tick();
        int sel = int'(cnt_cfg[3:2]);
        if (cnt_cfg[1:0] == 2'd0) return 1'b1;
        if (sel >= NCH) return 1'b0;
        case (cnt_cfg[1:0])
            2'd1:    return m_rise(sel);
            2'd2:    return m_fall(sel);
            default: return m_rise(sel) || m_fall(sel);
        endcase
    endfunction

    function automatic bit m_clear();
        int code = int'(cnt_cfg[7:5]);
        if (!cnt_cfg[4] || code >= 2*NCH) return 1'b0;
        return code[0] ? m_fall(code/2) : m_rise(code/2);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // continuous comparison every clock, away from the edges
    always @(negedge clk) begin
        #(CLK_P/4);
        if (armed && !rst) begin
            for (int c = 0; c < NCH; c++)
                chk("R3 capture value", 64'(cap_value[c*TW +: TW]), 64'(m_cap[c]));
            chk("R4 capture flags", 64'(cap_flags), 64'(m_flag));
            chk("R6 count tick", 64'(count_tick), 64'(m_tick()));
            chk("R8 timer clear", 64'(timer_clear), 64'(m_clear()));
        end
    end

    task automatic step();
        @(negedge clk);
        timer_val = timer_val + 32'd13;
        flag_clr  = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [TW-1:0] v;
        logic [15:0]   lfsr;
        lfsr = 16'hACE1;
        repeat (3) step();
        rst = 1'b0;
        armed = 1'b1;
        step();
        #1;
        // R1 reset state
        chk("R1 reset capture", 64'(cap_value[63:0]), 64'd0);
        chk("R1 reset flags", 64'(cap_flags), 64'd0);
        chk("R1 no clear after reset", 64'(timer_clear), 64'd0);

        // R2 latency on channel 0 rising, with interrupt enable
        cnt_cfg = 8'h00;
        cap_cfg = 9'b000_000_101;
        repeat (3) step();
        cap_pin[0] = 1'b1;
        step();
        step();
        v = timer_val;
        #1;
        chk("R2 capture not yet loaded", 64'(cap_value[TW-1:0]), 64'd0);
        step();
        #1;
        chk("R2 capture loaded with timer", 64'(cap_value[TW-1:0]), 64'(v));
        chk("R4 flag raised", 64'(cap_flags[0]), 64'd1);

        // R5 zero bits leave flag, one bit clears
        flag_clr = 3'b110;
        step();
        #1;
        chk("R5 zero clear bit keeps flag", 64'(cap_flags[0]), 64'd1);
        flag_clr = 3'b001;
        step();
        #1;
        chk("R5 clear bit drops flag", 64'(cap_flags[0]), 64'd0);

        // R4 set and clear in the same cycle, falling capture
        cap_cfg = 9'b000_000_110;
        cap_pin[0] = 1'b0;
        step();
        step();
        v = timer_val;
        flag_clr = 3'b001;
        step();
        #1;
        chk("R4 set wins over clear", 64'(cap_flags[0]), 64'd1);
        chk("R3 falling capture", 64'(cap_value[TW-1:0]), 64'(v));

        // R3 disabled edges do not capture
        cap_cfg = 9'b100_100_100;
        v = cap_value[TW-1:0];
        for (int i = 0; i < 12; i++) begin
            cap_pin = ~cap_pin;
            step();
        end
        #1;
        chk("R3 no capture without edge enable", 64'(cap_value[TW-1:0]), 64'(v));

        // R8 and R6: channel 1 falling clears, counting on falling of channel 1
        cap_pin = 3'b010;
        cnt_cfg = {3'd3, 1'b1, 2'd1, 2'd2};
        repeat (4) step();
        cap_pin[1] = 1'b0;
        step();
        #1;
        chk("R8 clear not early", 64'(timer_clear), 64'd0);
        step();
        #1;
        chk("R8 clear pulse", 64'(timer_clear), 64'd1);
        chk("R6 falling tick", 64'(count_tick), 64'd1);
        step();
        #1;
        chk("R8 clear single cycle", 64'(timer_clear), 64'd0);

        // R7 pin select 3 and R9 reserved clear codes while pins toggle
        for (int code = 6; code < 8; code++) begin
            cnt_cfg = {3'(code), 1'b1, 2'd3, 2'd3};
            for (int i = 0; i < 10; i++) begin
                cap_pin = ~cap_pin;
                step();
                #1;
                chk("R7 no tick for pin select 3", 64'(count_tick), 64'd0);
                chk("R9 no clear for reserved code", 64'(timer_clear), 64'd0);
            end
        end

        // pseudo-random sweep over every count mode, select and clear code
        for (int cfg = 0; cfg < 256; cfg += 7) begin
            cnt_cfg = 8'(cfg);
            cap_cfg = 9'(lfsr);
            for (int i = 0; i < 60; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (lfsr[3:2] == 2'b00) cap_pin = lfsr[NCH+3:4];
                if (lfsr[9:7] == 3'b000) flag_clr = lfsr[12:10];
                step();
            end
        end

        repeat (3) step();
        done = 1'b1;
        finish_run();
    end

endmodule